// File: doc/BRIEF.md
# Chip-Select Row Address Decoder

This block steers a physical memory address to one of several chip-select rows. Each row owns one 32-bit configuration word. The word packs an enable flag, a base address and a size mask. Configuration software loads the words through a plain one-word write port. The lookup side is purely combinational. An address presented on `lkp_addr` yields the following in the same cycle:

- a hit flag,
- the index of the winning row,
- the offset of the address inside that row,
- the row's size in bytes.

The base and mask both live in the upper address bits, from bit 23 upward. The mask field is widened with ones in bits 22:0, so the smallest row covers 8 MiB. Any mask up to all ones is legal. A row can therefore span the whole 4 GiB space, which is why the size output is 33 bits wide.

Both interfaces are plain control-style pins with no valid/ready pairing. A write is accepted on every clock edge where `cfg_we` is high. A lookup result is valid whenever `lkp_addr` is stable, so back-pressure never arises.

Top module: `csd_decoder`

## Requirements
- R1: An active-low asynchronous reset clears every row word, so after reset no address produces a hit.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the row named by `cfg_idx` on the next rising clock edge. Lookups see the new word from then on. Indices at or beyond the row count are dropped.
- R3: Bit 0 of a row word is the row enable. A row whose bit 0 is 0 never matches.
- R4: The row base is the row word with bits 22:0 forced to zero, that is, word bits 31:23 in place.
- R5: The row mask has bits 31:23 equal to word bits 15:7, and bits 22:0 all ones.
- R6: An enabled row matches when every address bit that is 0 in the row mask equals the same bit of the row base.
- R7: When several enabled rows match, the row with the lowest index wins.
- R8: On a hit, `row_off` equals the address ANDed with the winning row's mask.
- R9: On a hit, `row_size` equals the winning row's mask plus one, computed in 33 bits.
- R10: With no matching row, `hit`, `row_idx`, `row_off` and `row_size` are all 0.
- R11: Word bits 22:16 and 6:1, which hold the address-mode and reserved fields, have no effect on the decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Row word write strobe |
| cfg_idx | input | 3 | Row index of the write |
| cfg_wdata | input | 32 | Row word to store |
| lkp_addr | input | 32 | Physical address to decode |
| hit | output | 1 | An enabled row matches the address |
| row_idx | output | 3 | Winning row index, 0 when no hit |
| row_off | output | 32 | Address offset inside the winning row |
| row_size | output | 33 | Byte size of the winning row |

## Verification
Lookups are tried against the following row layouts, each aimed at a different fault:

- A minimum 8 MiB row. Probing its last byte and the first byte past it separates correct mask widening from an off-by-one boundary.
- A 64 MiB row. Its offset shows whether word bits 15:7 reach address bits 25:23.
- A disabled row that lies over a probed address.
- Two overlapping rows. These expose a wrong priority order.
- A word with every reserved and mode bit set. This exposes any leak of those bits into the base.
- A full-space row, followed by disabling row 0. These test the 33-bit size and the fall-through to a higher row.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int WORD_W   = 32;
  localparam int SEG_LSB  = 23;
  localparam int MFLD_LSB = 7;
  localparam int MFLD_W   = WORD_W - SEG_LSB;
  localparam int SIZE_W   = WORD_W + 1;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t row_base(input word_t w);
    return {w[WORD_W-1:SEG_LSB], {SEG_LSB{1'b0}}};
  endfunction

  function automatic word_t row_mask(input word_t w);
    return {w[MFLD_LSB+MFLD_W-1:MFLD_LSB], {SEG_LSB{1'b1}}};
  endfunction
endpackage

// File: rtl/csd_regfile.sv
module csd_regfile
  import csd_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  output word_t            words [ROWS]
);
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (we && (idx == IDX_W'(g))) begin
        words[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/csd_row_match.sv
module csd_row_match
  import csd_pkg::*;
(
  input  word_t word,
  input  word_t addr,
  output logic  match,
  output word_t mask
);
  word_t base;

  always_comb begin
    base  = row_base(word);
    mask  = row_mask(word);
    match = word[0] && (((addr ^ base) & ~mask) == '0);
  end
endmodule

// File: rtl/csd_prio_sel.sv
module csd_prio_sel
  import csd_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int IDX_W = $clog2(ROWS)
) (
  input  logic [ROWS-1:0]   match_vec,
  input  word_t             masks [ROWS],
  input  word_t             addr,
  output logic              hit,
  output logic [IDX_W-1:0]  sel_idx,
  output word_t             off,
  output logic [SIZE_W-1:0] size
);
  word_t sel_mask;

  always_comb begin
    hit      = 1'b0;
    sel_idx  = '0;
    sel_mask = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit      = 1'b1;
        sel_idx  = IDX_W'(i);
        sel_mask = masks[i];
      end
    end
    off  = addr & sel_mask;
    size = hit ? ({1'b0, sel_mask} + SIZE_W'(1)) : '0;
  end
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
  import csd_pkg::*;
#(
  parameter int ROWS = 8,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic [31:0]       lkp_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  row_idx,
  output logic [31:0]       row_off,
  output logic [SIZE_W-1:0] row_size
);
  word_t           words [ROWS];
  word_t           masks [ROWS];
  logic [ROWS-1:0] match_vec;
  logic [ROWS-1:0] en_vec;

  csd_regfile #(.ROWS(ROWS), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .wdata (cfg_wdata),
    .words (words)
  );

  for (genvar g = 0; g < ROWS; g++) begin : g_match
    assign en_vec[g] = words[g][0];
    csd_row_match u_match (
      .word  (words[g]),
      .addr  (lkp_addr),
      .match (match_vec[g]),
      .mask  (masks[g])
    );
  end

  csd_prio_sel #(.ROWS(ROWS), .IDX_W(IDX_W)) u_sel (
    .match_vec (match_vec),
    .masks     (masks),
    .addr      (lkp_addr),
    .hit       (hit),
    .sel_idx   (row_idx),
    .off       (row_off),
    .size      (row_size)
  );
endmodule

// File: rtl/csd_decoder_chk.sv
module csd_decoder_chk #(
  parameter int ROWS = 8,
  localparam int IDX_W = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [31:0]       cfg_wdata,
  input logic              hit,
  input logic [IDX_W-1:0]  row_idx,
  input logic [31:0]       row_off,
  input logic [32:0]       row_size,
  input logic [ROWS-1:0]   en_vec,
  input logic [ROWS-1:0]   match_vec
);
  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (en_vec == '0));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[0]) |=> en_vec[$past(cfg_idx)]);

  p_only_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> en_vec[row_idx]);

  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match_vec[row_idx] &&
             ((match_vec & ((ROWS'(1) << row_idx) - ROWS'(1))) == '0)));

  p_off_in_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((row_size != '0) && ({1'b0, row_off} < row_size)));

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> ((row_idx == '0) && (row_off == '0) && (row_size == '0)));
endmodule

bind csd_decoder csd_decoder_chk #(.ROWS(ROWS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_idx   (cfg_idx),
  .cfg_wdata (cfg_wdata),
  .hit       (hit),
  .row_idx   (row_idx),
  .row_off   (row_off),
  .row_size  (row_size),
  .en_vec    (en_vec),
  .match_vec (match_vec)
);

// File: tb/csd_decoder_tb.sv
module csd_decoder_tb;
  typedef struct {
    logic [31:0] addr;
    logic        hit;
    logic [2:0]  idx;
    logic [31:0] off;
    logic [32:0] size;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] lkp_addr = '0;
  logic        hit;
  logic [2:0]  row_idx;
  logic [31:0] row_off;
  logic [32:0] row_size;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];
  logic [31:0] shadow [8];

  always #10 clk = ~clk;

  csd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lkp_addr(lkp_addr), .hit(hit),
    .row_idx(row_idx), .row_off(row_off), .row_size(row_size)
  );

  task automatic wr_row(input int r, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(r); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[r] = w;
  endtask

  task automatic lookup(input logic [31:0] a, input string tag);
    exp_t e;
    e.addr = a; e.hit = 1'b0; e.idx = '0; e.off = '0; e.size = '0; e.tag = tag;
    for (int r = 7; r >= 0; r--) begin
      logic [31:0] b, m;
      b = shadow[r] & 32'hFF80_0000;
      m = ((shadow[r] & 32'h0000_FF80) << 16) | 32'h007F_FFFF;
      if (shadow[r][0] && (((a ^ b) & ~m) == 32'h0)) begin
        e.hit = 1'b1; e.idx = 3'(r); e.off = a & m; e.size = {1'b0, m} + 33'd1;
      end
    end
    @(negedge clk);
    lkp_addr = a;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (hit !== e.hit || row_idx !== e.idx || row_off !== e.off || row_size !== e.size) begin
          n_errors++;
          $display("FAIL %s addr=%h actual hit=%b idx=%0d off=%h size=%h expected hit=%b idx=%0d off=%h size=%h",
                   e.tag, e.addr, hit, row_idx, row_off, row_size, e.hit, e.idx, e.off, e.size);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : driver
    for (int r = 0; r < 8; r++) shadow[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lookup(32'h0000_0000, "R1 reset no hit");
    lookup(32'hFFFF_FFFF, "R1 reset no hit top");
    wr_row(0, 32'h0000_0001);
    lookup(32'h0012_3456, "R2 R5 R8 R9 8MiB row");
    lookup(32'h007F_FFFF, "R5 last byte of row0");
    lookup(32'h0080_0000, "R6 R10 past row0");
    wr_row(3, 32'h1000_0381);
    lookup(32'h1234_5678, "R4 R5 R8 64MiB row3");
    lookup(32'h1400_0000, "R6 R10 past row3");
    wr_row(5, 32'h2000_0000);
    lookup(32'h2000_0010, "R3 disabled row5");
    wr_row(1, 32'h1000_0001);
    lookup(32'h1000_0004, "R7 overlap lowest row1");
    lookup(32'h1200_0000, "R7 overlap only row3");
    wr_row(6, 32'h407F_007F);
    lookup(32'h4000_0100, "R11 reserved bits row6");
    lookup(32'h4080_0000, "R11 base not widened");
    wr_row(7, 32'h0000_FF81);
    lookup(32'hF000_0000, "R9 full-space row7");
    lookup(32'h0000_0040, "R7 row0 over row7");
    wr_row(0, 32'h0000_0000);
    lookup(32'h0012_3456, "R2 R3 row0 disabled falls to row7");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule